// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a row of scan cells placed between a device's core logic and its pins, one cell per pin. Input-pin cells sit on the path from a pin into the core. Output-pin cells sit on the path from the core out to a pin. In normal mode every path is a straight wire. In test mode the core is cut off from its pins: the values on the core inputs and on the pins come from stored cell contents.

All cells are linked into one serial path from `tdi` to `tdo`, clocked by `tck`. A test controller drives four strobes. A capture strobe samples live values into the shift stages. A shift strobe moves the chain one place toward `tdo`. An update strobe copies the shift stages into the update stages that feed the outputs. A test-mode select chooses between live and stored values.

The top decodes the strobes into one of three named cell operations. `OP_HOLD` is the default when no strobe is active. `OP_CAPTURE` is taken when the capture strobe is high, from any operation. `OP_SHIFT` is taken when the shift strobe is high and the capture strobe is low. The operation is re-decoded on every rising `tck` edge. The update stages run separately on the falling edge.

Top module: `bsc_chain`

## Requirements
- R1: While `rst_n` is low, every shift stage and every update stage is 0. In test mode this gives `tdo` = 0, `core_in` = 0 and `pin_out` = 0.
- R2: When `test_mode` = 0, `core_in` equals `pin_in` and `pin_out` equals `core_out`, combinationally, whatever the contents of the cells.
- R3: When `test_mode` = 1, `core_in` and `pin_out` come only from the update stages. Changes on `pin_in` and `core_out` do not reach them.
- R4: On a rising `tck` edge with `capture_en` = 1, the shift stage of input pin i loads `pin_in[i]`. The shift stage of output pin j loads the value it currently drives on `pin_out[j]`.
- R5: Input pin i is at chain position i, and output pin j is at chain position N_IN+j, where N = N_IN+N_OUT. On a rising edge with `shift_en` = 1 and `capture_en` = 0, position N-1 loads `tdi` and every other position k loads position k+1. `tdo` always shows position 0, so bit 0 leaves first.
- R6: On a falling `tck` edge with `update_en` = 1, each update stage loads its shift stage. Otherwise the update stages hold, so in test mode the outputs stay steady through capture and shift.
- R7: When `capture_en` and `shift_en` are both 1, capture takes precedence.
- R8: On a rising edge with neither `capture_en` nor `shift_en` set, the shift stages keep their contents, whatever `tdi` or the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into chain position N-1 |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe, acted on at the falling edge |
| test_mode | input | 1 | 1 selects stored values, 0 passes live values |
| pin_in | input | N_IN | Values arriving at the input pins |
| core_out | input | N_OUT | Values the core wants on the output pins |
| core_in | output | N_IN | Values delivered to the core |
| pin_out | output | N_OUT | Values driven onto the output pins |
| tdo | output | 1 | Serial data from chain position 0 |

## Verification
Several pass-through patterns are applied in normal mode: all ones, alternating bits, and mixed values. Together they separate a correct wire from a swapped index or a stuck bit. A capture in normal mode, shifted out with distinct values on each side, shows both the chain order and which live source each cell type samples. A second capture taken in test mode shows that output cells sample the driven pin rather than the core. Asserting capture and shift together, followed by idle edges with `tdi` toggling, separates the precedence rule from the hold rule. Checking the outputs on every edge during shifting catches any ripple from the shift stages into the update stages.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
package bsc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } scan_op_e;

    // capture outranks shift
    function automatic scan_op_e decode_op(input logic cap, input logic shf);
        if (cap)
            return OP_CAPTURE;
        else if (shf)
            return OP_SHIFT;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/bsc_mux.sv
`timescale 1ns/1ps
module bsc_mux (
    input  logic test_mode,
    input  logic live,
    input  logic stored,
    output logic drive
);
    always_comb begin
        drive = test_mode ? stored : live;
    end
endmodule

// File: rtl/bsc_cell.sv
`timescale 1ns/1ps
module bsc_cell
    import bsc_pkg::*;
#(
    parameter bit IS_OUTPUT = 1'b0
) (
    input  logic     tck,
    input  logic     rst_n,
    input  scan_op_e op,
    input  logic     update_en,
    input  logic     test_mode,
    input  logic     ser_in,
    input  logic     live,
    output logic     sh_q,
    output logic     drive
);
    logic up_q;
    logic cap_src;

    // an output cell samples what it puts on the pin, an input cell the pin itself
    generate
        if (IS_OUTPUT) begin : g_out
            assign cap_src = drive;
        end else begin : g_in
            assign cap_src = live;
        end
    endgenerate

    // shift stage: rising edge
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= 1'b0;
        end else begin
            unique case (op)
                OP_CAPTURE: sh_q <= cap_src;
                OP_SHIFT:   sh_q <= ser_in;
                default:    sh_q <= sh_q;
            endcase
        end
    end

    // update stage: falling edge
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)
            up_q <= 1'b0;
        else if (update_en)
            up_q <= sh_q;
    end

    bsc_mux u_mux (
        .test_mode (test_mode),
        .live      (live),
        .stored    (up_q),
        .drive     (drive)
    );

    AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
        op == OP_CAPTURE |=> sh_q == $past(cap_src)); // R4

    AST_SHIFT_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
        op == OP_SHIFT |=> sh_q == $past(ser_in)); // R5

    AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        op == OP_HOLD |=> $stable(sh_q)); // R8

    AST_UPDATE_LOAD: assert property (@(negedge tck) disable iff (!rst_n)
        update_en |=> up_q == $past(sh_q)); // R6

    AST_UPDATE_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
        !update_en |=> $stable(up_q)); // R6

endmodule

// File: rtl/bsc_chain.sv
`timescale 1ns/1ps
module bsc_chain
    import bsc_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tdi,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             test_mode,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_IN-1:0]  core_in,
    output logic [N_OUT-1:0] pin_out,
    output logic             tdo
);
    localparam int N = N_IN + N_OUT;

    scan_op_e       op;
    logic [N-1:0]   sh_bus;
    logic [N-1:0]   ser_vec;

    always_comb begin
        op = decode_op(capture_en, shift_en);
    end

    assign ser_vec = {tdi, sh_bus[N-1:1]};
    assign tdo     = sh_bus[0];

    generate
        for (genvar k = 0; k < N; k++) begin : g_cell
            if (k < N_IN) begin : g_in
                bsc_cell #(.IS_OUTPUT(1'b0)) u_cell (
                    .tck       (tck),
                    .rst_n     (rst_n),
                    .op        (op),
                    .update_en (update_en),
                    .test_mode (test_mode),
                    .ser_in    (ser_vec[k]),
                    .live      (pin_in[k]),
                    .sh_q      (sh_bus[k]),
                    .drive     (core_in[k])
                );
            end else begin : g_out
                bsc_cell #(.IS_OUTPUT(1'b1)) u_cell (
                    .tck       (tck),
                    .rst_n     (rst_n),
                    .op        (op),
                    .update_en (update_en),
                    .test_mode (test_mode),
                    .ser_in    (ser_vec[k]),
                    .live      (core_out[k-N_IN]),
                    .sh_q      (sh_bus[k]),
                    .drive     (pin_out[k-N_IN])
                );
            end
        end
    endgenerate

    AST_CAPTURE_WINS: assert property (@(posedge tck) disable iff (!rst_n)
        capture_en && shift_en |=> tdo == $past(pin_in[0])); // R7

    AST_NORMAL_PASS: assert property (@(posedge tck) disable iff (!rst_n)
        !test_mode |-> pin_out == core_out && core_in == pin_in); // R2

endmodule

// File: tb/tb_bsc_chain.sv
`timescale 1ns/1ps
module tb_bsc_chain;
    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int N     = N_IN + N_OUT;

    logic             tck = 1'b0;
    logic             rst_n = 1'b0;
    logic             tdi = 1'b0;
    logic             capture_en = 1'b0;
    logic             shift_en = 1'b0;
    logic             update_en = 1'b0;
    logic             test_mode = 1'b0;
    logic [N_IN-1:0]  pin_in = '0;
    logic [N_OUT-1:0] core_out = '0;
    logic [N_IN-1:0]  core_in;
    logic [N_OUT-1:0] pin_out;
    logic             tdo;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    bit exp_q[$];
    bit done = 1'b0;

    always #10 tck = ~tck;

    bsc_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) dut (
        .tck(tck), .rst_n(rst_n), .tdi(tdi),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .test_mode(test_mode), .pin_in(pin_in), .core_out(core_out),
        .core_in(core_in), .pin_out(pin_out), .tdo(tdo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: pop one expected tdo bit on each falling edge of a shift tick
    always @(negedge tck) begin
        if (mon_en) begin
            if (exp_q.size() == 0) begin
                chk("R5 queue underflow", 32'd1, 32'd0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk("R5 tdo serial order", {31'd0, tdo}, {31'd0, e});
            end
        end
    end

    task automatic tick();
        @(posedge tck);
        #5;
    endtask

    // driver: push expected chain contents, shift in new data, watch pins stay put
    task automatic shift_all(input logic [N-1:0] expect_out, input logic [N-1:0] load,
                             input bit watch, input logic [N_OUT-1:0] hold_pins);
        for (int i = 0; i < N; i++) exp_q.push_back(expect_out[i]);
        for (int i = 0; i < N; i++) begin
            tdi = load[i];
            shift_en = 1'b1;
            mon_en = 1'b1;
            tick();
            if (watch) chk("R6 pins steady while shifting", 32'(pin_out), 32'(hold_pins));
        end
        shift_en = 1'b0;
        mon_en = 1'b0;
    endtask

    task automatic capture_tick();
        capture_en = 1'b1;
        tick();
        capture_en = 1'b0;
    endtask

    task automatic update_tick();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            chk("watchdog expired", 32'd1, 32'd0);
            report();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] load_a;
        logic [N-1:0] load_b;
        logic [N_IN-1:0] c1;
        logic [N_IN-1:0] c2;

        // R1: reset state
        test_mode = 1'b1;
        pin_in = 4'hF;
        core_out = 4'hF;
        tick(); tick();
        chk("R1 tdo after reset", {31'd0, tdo}, 32'd0);
        chk("R1 core_in after reset", 32'(core_in), 32'd0);
        chk("R1 pin_out after reset", 32'(pin_out), 32'd0);
        rst_n = 1'b1;
        tick();

        // R2: pass-through patterns in normal mode
        test_mode = 1'b0;
        pin_in = 4'hF; core_out = 4'hF; #1;
        chk("R2 core_in ones", 32'(core_in), 32'hF);
        chk("R2 pin_out ones", 32'(pin_out), 32'hF);
        pin_in = 4'h5; core_out = 4'hA; #1;
        chk("R2 core_in alt", 32'(core_in), 32'h5);
        chk("R2 pin_out alt", 32'(pin_out), 32'hA);
        pin_in = 4'h3; core_out = 4'h9; #1;
        chk("R2 core_in mixed", 32'(core_in), 32'h3);
        chk("R2 pin_out mixed", 32'(pin_out), 32'h9);

        // R4, R5: capture in normal mode, output cells see core_out on the pin
        capture_tick();
        load_a = 8'b1011_0110;
        shift_all({4'h9, 4'h3}, load_a, 1'b0, '0);

        // R6: update, then R3 in test mode
        update_tick();
        test_mode = 1'b1; #1;
        chk("R6 core_in after update", 32'(core_in), 32'(load_a[N_IN-1:0]));
        chk("R6 pin_out after update", 32'(pin_out), 32'(load_a[N-1:N_IN]));
        pin_in = 4'hC; core_out = 4'h0; #1;
        chk("R3 core_in isolated", 32'(core_in), 32'(load_a[N_IN-1:0]));
        chk("R3 pin_out isolated", 32'(pin_out), 32'(load_a[N-1:N_IN]));

        // R4: capture in test mode, output cells see the stored pin value
        c1 = 4'hC;
        capture_tick();
        load_b = 8'b0100_1101;
        shift_all({load_a[N-1:N_IN], c1}, load_b, 1'b1, load_a[N-1:N_IN]);
        chk("R6 core_in steady after shift", 32'(core_in), 32'(load_a[N_IN-1:0]));

        // R7: capture and shift together; R8: idle edges hold
        c2 = 4'h6;
        pin_in = c2;
        capture_en = 1'b1;
        shift_en = 1'b1;
        tdi = 1'b1;
        tick();
        capture_en = 1'b0;
        shift_en = 1'b0;
        chk("R7 capture wins tdo", {31'd0, tdo}, {31'd0, c2[0]});
        tdi = 1'b0; pin_in = 4'h9; tick();
        tdi = 1'b1; pin_in = 4'h0; tick();
        chk("R8 tdo held", {31'd0, tdo}, {31'd0, c2[0]});
        shift_all({load_a[N-1:N_IN], c2}, '0, 1'b1, load_a[N-1:N_IN]);

        // R1: reset in mid-run clears stored values
        rst_n = 1'b0; #1;
        chk("R1 pin_out on re-reset", 32'(pin_out), 32'd0);
        chk("R1 core_in on re-reset", 32'(core_in), 32'd0);
        tick();
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        report();
        $finish;
    end
endmodule